// File: doc/BRIEF.md
# Receive Descriptor Poll Scheduler

This block decides the cycles in which the buffer management logic fetches the next receive descriptor from the ring. A down-counter loaded from a programmable period normally triggers each fetch. Software can also raise a demand that forces a fetch at once, bypassing the counter. A control input switches automatic polling off, so that only demands lead to fetches. The receiver enable gates everything.

The block emits a one-cycle `fetch_req` pulse and waits for a `fetch_done` pulse from the fetch engine before it issues another. The demand bit clears itself once its fetch has been requested. The counter reloads after every fetch, whatever caused it, so that periodic polling carries on from the most recent access.

Top module: `rx_desc_poll_sched`

## Requirements
- R1: While `rx_en` is 1 and no fetch is outstanding, a `demand_set` pulse raises `fetch_req` in the cycle after the pulse, whatever the counter holds.
- R2: While `rx_en` is 0, `fetch_req` stays 0 and a `demand_set` pulse leaves `demand_pending` at 0.
- R3: While `auto_poll_off` is 1, `fetch_req` rises only because of a demand; the counter never triggers a fetch.
- R4: With automatic polling on, `fetch_req` rises `poll_period` cycles after `rx_en` goes to 1 from an idle state.
- R5: After any fetch, whether demanded or timed, the counter restarts from `poll_period` once `fetch_done` has been seen, so the next timed request comes `poll_period` + 1 cycles after the `fetch_done` cycle.
- R6: `demand_pending` reads 0 in the cycle after `fetch_req`, and a demand raised while a fetch is outstanding merges into it: no extra request follows.
- R7: At most one fetch is outstanding: after `fetch_req`, `busy` is 1 and no new `fetch_req` appears until the cycle after `fetch_done`.
- R8: Dropping `rx_en` reloads the counter and clears any pending demand, so re-enabling waits a full `poll_period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; gates all fetch activity |
| auto_poll_off | input | 1 | 1 disables timer-driven fetches |
| poll_period | input | CNT_W | Cycles between timed fetches |
| demand_set | input | 1 | One-cycle software demand for an immediate fetch |
| fetch_done | input | 1 | One-cycle completion of the outstanding fetch |
| fetch_req | output | 1 | One-cycle request to fetch the next receive descriptor |
| demand_pending | output | 1 | Self-clearing demand bit as seen by software |
| busy | output | 1 | A fetch has been requested and not yet completed |

## Verification
The hardest case to reach is a demand that lands while a fetch is still in flight, because a demand against an idle block is served the next cycle and never lingers. The bench stretches the fetch engine's response to eight cycles, issues a demand in the middle of that window, and then confirms that the demand bit reads clear and that no second request follows once the fetch completes. The counter reload on disable is exposed by cutting the enable partway through a count and timing the first request after re-enable.

// File: rtl/rx_desc_poll_sched.sv
module rx_desc_poll_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             auto_poll_off,
  input  logic [CNT_W-1:0] poll_period,
  input  logic             demand_set,
  input  logic             fetch_done,
  output logic             fetch_req,
  output logic             demand_pending,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;
  logic             dem_q;
  logic             busy_q;

  wire expired = !auto_poll_off && (cnt_q == '0);

  assign fetch_req      = rx_en && !busy_q && (dem_q || expired);
  assign demand_pending = dem_q;
  assign busy           = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      dem_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (fetch_req)       busy_q <= 1'b1;
      else if (fetch_done) busy_q <= 1'b0;

      dem_q <= rx_en && !fetch_req && (dem_q || (demand_set && !busy_q));

      if (!rx_en || fetch_req)
        cnt_q <= poll_period;
      else if (!busy_q && !auto_poll_off && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

module rx_desc_poll_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic auto_poll_off,
  input logic demand_set,
  input logic fetch_done,
  input logic fetch_req,
  input logic demand_pending,
  input logic busy
);

  a_r1_demand_fires: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && demand_pending && !busy |-> fetch_req);

  a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !fetch_req);

  a_r3_demand_only: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && auto_poll_off && !demand_pending |-> !fetch_req);

  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !demand_pending);

  a_r6_merge: assert property (@(posedge clk) disable iff (!rst_n)
    busy && demand_set |=> !demand_pending);

  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> busy && !fetch_req);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fetch_done |=> busy);

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !demand_pending);

endmodule

bind rx_desc_poll_sched rx_desc_poll_sched_chk u_chk (.*);

// File: tb/rx_desc_poll_sched_tb.sv
`timescale 1ns/1ps
module rx_desc_poll_sched_tb;
  localparam int W = 16;
  localparam int P = 5;

  logic clk = 0, rst_n = 0, rx_en = 0, auto_poll_off = 0, demand_set = 0, fetch_done = 0;
  logic [W-1:0] poll_period = W'(P);
  logic fetch_req, demand_pending, busy;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int rsp_dly = 2;
  int done_at = -1;
  int exp_cyc[$];
  string exp_tag[$];

  rx_desc_poll_sched #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .auto_poll_off(auto_poll_off),
    .poll_period(poll_period), .demand_set(demand_set), .fetch_done(fetch_done),
    .fetch_req(fetch_req), .demand_pending(demand_pending), .busy(busy));

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_req(input int at, input string tag);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic go_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_demand();
    demand_set = 1;
    @(negedge clk);
    demand_set = 0;
  endtask

  always @(negedge clk) begin
    fetch_done <= (cyc == done_at);
    if (rst_n && fetch_req) begin
      done_at = cyc + rsp_dly;
      if (exp_cyc.size() == 0) begin
        chk(0, "R3/R6/R7 unexpected fetch_req", cyc, -1);
      end else begin
        int e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        chk(cyc == e, t, cyc, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_req == 0, "reset fetch_req", fetch_req, 0);
    chk(demand_pending == 0, "reset demand_pending", demand_pending, 0);
    chk(busy == 0, "reset busy", busy, 0);

    // R4 / R5: timed polling
    c = cyc;
    expect_req(c + P, "R4 first timed request");
    expect_req(c + 2*P + rsp_dly + 1, "R5 timed reload");
    rx_en = 1;
    go_to(c + 2*P + rsp_dly + 2);
    rx_en = 0;
    go_to(cyc + 6);

    // R1 / R5: demand bypasses the counter, polling resumes
    c = cyc;
    expect_req(c + 1, "R1 demand immediate");
    expect_req(c + 1 + rsp_dly + 1 + P, "R5 reload after demand");
    rx_en = 1;
    pulse_demand();
    go_to(c + 2 + rsp_dly + 1 + P);
    rx_en = 0;
    go_to(cyc + 6);

    // R3: automatic polling off
    auto_poll_off = 1;
    rx_en = 1;
    c = cyc;
    go_to(c + 3*P);
    expect_req(c + 3*P + 1, "R3 demand with auto off");
    pulse_demand();
    go_to(c + 6*P);
    rx_en = 0;
    go_to(cyc + 4);

    // R6 / R7: demand merged into an outstanding fetch
    rsp_dly = 8;
    rx_en = 1;
    c = cyc;
    expect_req(c + 1, "R1 demand with long fetch");
    pulse_demand();
    go_to(c + 4);
    pulse_demand();
    chk(demand_pending == 0, "R6 merged demand", demand_pending, 0);
    chk(busy == 1, "R7 busy while outstanding", busy, 1);
    go_to(c + 20);
    expect_req(c + 21, "R6 next demand after merge");
    pulse_demand();
    go_to(c + 22);
    rx_en = 0;
    go_to(c + 35);
    rsp_dly = 2;
    auto_poll_off = 0;

    // R2: demand ignored while disabled
    pulse_demand();
    chk(demand_pending == 0, "R2 demand ignored", demand_pending, 0);
    go_to(cyc + 3);

    // R8: disable mid-count reloads the counter
    c = cyc;
    rx_en = 1;
    go_to(c + 3);
    rx_en = 0;
    go_to(c + 6);
    expect_req(c + 6 + P, "R8 full period after re-enable");
    rx_en = 1;
    go_to(c + 7 + P);
    rx_en = 0;
    go_to(cyc + 6);

    chk(exp_cyc.size() == 0, "R4 all expected requests seen", exp_cyc.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule